// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the addresses of a short burst for a synchronous pipelined memory. A controller presents a starting address together with one of two address strobes: one meant for a processor, one for a cache controller. The block captures that address and starts a burst at beat 0. Each later clock edge where the active-low advance input is low moves the burst to the next beat. After the last beat, the burst ends.

Only the low bits that index a beat inside the burst window change. The upper bits keep the value that was loaded. A static order-select input chooses between two beat orders:
- a wrapping linear count;
- an interleaved order, formed by XOR of the loaded low bits with a running beat counter.

The outputs are the current full address, a flag that shows a burst is in progress, and the beat index. These outputs come straight from registered state, so they change one clock after the input that causes the change.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0, `burst_active` is 0 and `beat_idx` is 0.
- R2: A clock edge with `strb_cpu` high loads `addr_cpu`. After that edge, `addr_out` equals `addr_cpu`, `beat_idx` is 0 and `burst_active` is 1.
- R3: A clock edge with `strb_cache` high and `strb_cpu` low loads `addr_cache`. After that edge, `addr_out` equals `addr_cache`, `beat_idx` is 0 and `burst_active` is 1.
- R4: When both strobes are high at the same edge, the processor strobe wins and `addr_cpu` is loaded.
- R5: During a burst, an edge with `adv_n` low and no strobe raises `beat_idx` by one.
- R6: During a burst, an edge with `adv_n` high and no strobe leaves `addr_out`, `beat_idx` and `burst_active` unchanged.
- R7: With `order_il` = 0 (linear order), the two low address bits are (loaded low bits + `beat_idx`) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R8: With `order_il` = 1 (interleaved order), the two low address bits are (loaded low bits XOR `beat_idx`). For example, a start of 1 gives 1, 0, 3, 2, and a start of 3 gives 3, 2, 1, 0.
- R9: Address bits above bit 1 hold the loaded value for the whole burst. A wrap in the low field never carries into them.
- R10: A load yields exactly four beats. An advance while `beat_idx` is 3 ends the burst: `burst_active` becomes 0, `beat_idx` becomes 0, and `addr_out` returns to the loaded start address.
- R11: While no burst is active, an edge with `adv_n` low and no strobe has no effect on any output.
- R12: A strobe in the middle of a burst reloads the address and restarts at beat 0, even when `adv_n` is low at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_cpu | input | 1 | Processor address strobe; starts a burst at `addr_cpu` |
| addr_cpu | input | ADDR_W | Start address captured with `strb_cpu` |
| strb_cache | input | 1 | Cache-controller address strobe; starts a burst at `addr_cache` |
| addr_cache | input | ADDR_W | Start address captured with `strb_cache` |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_il | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | High while a burst is in progress |
| beat_idx | output | BEAT_W | Beat number within the burst, 0 to 3 |

## Verification
The bench aims at the edges of the four-beat window:
- **Start 3 in linear order.** The low field must wrap to 0 without touching the upper bits. A carry that leaks into the upper bits would show up as a wrong full address.
- **Advance on beat 3.** The burst must stop there. A counter that wraps freely would keep `burst_active` high and run a fifth beat.
- **Holds and idle advances.** These are placed between beats. A design that advances without a burst, or that ignores `adv_n` high, would show a moved `beat_idx`.
- **Strobe collisions.** Both strobes are raised together, and a strobe is raised during an advance. Wrong priority would load the cache address. Letting the advance win would leave the beat index non-zero after the reload.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Selects how the beat order is chosen
   localparam int ORDER_PIN    = 0;  // order_il input picks at run time
   localparam int ORDER_LINEAR = 1;  // fixed wrapping count
   localparam int ORDER_XOR    = 2;  // fixed interleaved order

   typedef enum logic [1:0] {
      LD_NONE  = 2'd0,
      LD_CPU   = 2'd1,
      LD_CACHE = 2'd2
   } load_src_e;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/bseq_load_arb.sv
module bseq_load_arb
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              strb_cpu,
   input  logic [ADDR_W-1:0] addr_cpu,
   input  logic              strb_cache,
   input  logic [ADDR_W-1:0] addr_cache,
   output logic              load,
   output logic [ADDR_W-1:0] load_addr
);

   load_src_e src;

   // The processor strobe has fixed priority over the cache strobe
   always_comb begin
      if (strb_cpu)        src = LD_CPU;
      else if (strb_cache) src = LD_CACHE;
      else                 src = LD_NONE;
   end

   always_comb begin
      unique case (src)
         LD_CPU:   load_addr = addr_cpu;
         LD_CACHE: load_addr = addr_cache;
         default:  load_addr = '0;
      endcase
   end

   assign load = (src != LD_NONE);

   always_comb begin
      if (strb_cpu && strb_cache)
         assert_prio_R4: assert (src == LD_CPU);
   end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int BURST_LEN = 4,
   parameter int BEAT_W    = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv_n,
   output logic [BEAT_W-1:0] beat,
   output logic              active,
   output logic              last
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

   logic step;

   assign last = (beat == LAST_BEAT);
   assign step = active && !adv_n && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat   <= '0;
         active <= 1'b0;
      end else if (load) begin
         beat   <= '0;
         active <= 1'b1;
      end else if (step) begin
         if (last) begin
            beat   <= '0;
            active <= 1'b0;
         end else begin
            beat   <= beat + 1'b1;
         end
      end
   end

   assert_adv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !adv_n && !load && !last) |=> (active && beat == $past(beat) + 1'b1));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && adv_n && !load) |=> ($stable(beat) && active));

   assert_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !adv_n && !load && last) |=> (!active && beat == '0));

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> (!active && $stable(beat)));

   assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (active && beat == '0));

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W     = 2,
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] beat,
   input  logic              order_il,
   output logic [BEAT_W-1:0] beat_lo
);

   logic [BEAT_W-1:0] lin_lo;
   logic [BEAT_W-1:0] xor_lo;

   assign lin_lo = start_lo + beat;   // wraps within the window
   assign xor_lo = start_lo ^ beat;

   generate
      if (ORDER_MODE == ORDER_LINEAR) begin : g_lin
         logic unused_sel;
         assign unused_sel = order_il ^ (|xor_lo);
         assign beat_lo    = lin_lo;
      end else if (ORDER_MODE == ORDER_XOR) begin : g_xor
         logic unused_sel;
         assign unused_sel = order_il ^ (|lin_lo);
         assign beat_lo    = xor_lo;
      end else begin : g_pin
         assign beat_lo = order_il ? xor_lo : lin_lo;
      end
   endgenerate

   // Both orders begin on the loaded start field
   always_comb begin
      if (beat == '0)
         assert_first_beat_R7: assert (beat_lo == start_lo);
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int BURST_LEN  = 4,
   parameter int ORDER_MODE = ORDER_PIN,
   localparam int BEAT_W    = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strb_cpu,
   input  logic [ADDR_W-1:0] addr_cpu,
   input  logic              strb_cache,
   input  logic [ADDR_W-1:0] addr_cache,
   input  logic              adv_n,
   input  logic              order_il,
   output logic [ADDR_W-1:0] addr_out,
   output logic              burst_active,
   output logic [BEAT_W-1:0] beat_idx
);

   localparam int HI_W = ADDR_W - BEAT_W;

   // Elaboration-time parameter checks
   if (!is_pow2(BURST_LEN)) begin : g_bad_len
      $error("burst_addr_seq: BURST_LEN must be a power of two of at least 2");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed the beat field width");
   end
   if (ORDER_MODE < ORDER_PIN || ORDER_MODE > ORDER_XOR) begin : g_bad_mode
      $error("burst_addr_seq: ORDER_MODE out of range");
   end

   logic              load_w;
   logic [ADDR_W-1:0] load_addr_w;
   logic [ADDR_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_w;
   logic              active_w;
   logic              last_w;
   logic [BEAT_W-1:0] beat_lo_w;
   logic              use_xor;

   bseq_load_arb #(.ADDR_W(ADDR_W)) u_arb (
      .strb_cpu   (strb_cpu),
      .addr_cpu   (addr_cpu),
      .strb_cache (strb_cache),
      .addr_cache (addr_cache),
      .load       (load_w),
      .load_addr  (load_addr_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      start_q <= '0;
      else if (load_w) start_q <= load_addr_w;
   end

   bseq_beat_ctr #(.BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_w),
      .adv_n  (adv_n),
      .beat   (beat_w),
      .active (active_w),
      .last   (last_w)
   );

   bseq_order_map #(.BEAT_W(BEAT_W), .ORDER_MODE(ORDER_MODE)) u_map (
      .start_lo (start_q[BEAT_W-1:0]),
      .beat     (beat_w),
      .order_il (order_il),
      .beat_lo  (beat_lo_w)
   );

   assign addr_out     = {start_q[ADDR_W-1:BEAT_W], beat_lo_w};
   assign burst_active = active_w;
   assign beat_idx     = beat_w;

   generate
      if (ORDER_MODE == ORDER_LINEAR)   begin : g_ord_lin assign use_xor = 1'b0;     end
      else if (ORDER_MODE == ORDER_XOR) begin : g_ord_xor assign use_xor = 1'b1;     end
      else                              begin : g_ord_pin assign use_xor = order_il; end
   endgenerate

   assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      strb_cpu |=> (addr_out == $past(addr_cpu) && burst_active && beat_idx == '0));

   assert_cache_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_cache && !strb_cpu) |=> (addr_out == $past(addr_cache) && burst_active));

   assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && adv_n && !strb_cpu && !strb_cache) |=> $stable(addr_out));

   assert_linear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && !load_w && !use_xor && !order_il) |=>
         ((addr_out[BEAT_W-1:0] - beat_idx) == $past(addr_out[BEAT_W-1:0] - beat_idx)));

   assert_xor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && !load_w && use_xor && $stable(order_il)) |=>
         ((addr_out[BEAT_W-1:0] ^ beat_idx) == $past(addr_out[BEAT_W-1:0] ^ beat_idx)));

   assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && !load_w) |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

   assert_idle_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_active && !load_w) |=> $stable(addr_out));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

   localparam int AW = 20;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          act;
      logic [1:0]    beat;
      logic [7:0]    tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strb_cpu = 1'b0, strb_cache = 1'b0, adv_n = 1'b1, order_il = 1'b0;
   logic [AW-1:0] addr_cpu = '0, addr_cache = '0;
   logic [AW-1:0] addr_out;
   logic          burst_active;
   logic [1:0]    beat_idx;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;
   exp_t sb_q[$];

   // model state, derived from the requirements
   logic [AW-1:0] m_start = '0;
   logic [1:0]    m_beat  = '0;
   logic          m_act   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   burst_addr_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .strb_cpu(strb_cpu), .addr_cpu(addr_cpu),
      .strb_cache(strb_cache), .addr_cache(addr_cache),
      .adv_n(adv_n), .order_il(order_il),
      .addr_out(addr_out), .burst_active(burst_active), .beat_idx(beat_idx)
   );

   task automatic chk(input int tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL R%0d %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, push the expected result
   task automatic step(input bit sc, input logic [AW-1:0] ac, input bit sk,
                       input logic [AW-1:0] ak, input bit an, input int tag);
      exp_t e;
      logic [1:0] lo;
      strb_cpu = sc; addr_cpu = ac; strb_cache = sk; addr_cache = ak; adv_n = an;
      @(posedge clk);
      if (sc)      begin m_start = ac; m_beat = 2'd0; m_act = 1'b1; end
      else if (sk) begin m_start = ak; m_beat = 2'd0; m_act = 1'b1; end
      else if (m_act && !an) begin
         if (m_beat == 2'd3) begin m_act = 1'b0; m_beat = 2'd0; end
         else m_beat = m_beat + 2'd1;
      end
      lo     = order_il ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
      e.addr = {m_start[AW-1:2], lo};
      e.act  = m_act;
      e.beat = m_beat;
      e.tag  = 8'(tag);
      sb_q.push_back(e);
      #2;
   endtask

   // monitor: compare outputs mid-cycle against the scoreboard
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk(int'(e.tag), "addr_out", 32'(addr_out), 32'(e.addr));
         chk(int'(e.tag), "burst_active", 32'(burst_active), 32'(e.act));
         chk(int'(e.tag), "beat_idx", 32'(beat_idx), 32'(e.beat));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(1, "reset addr_out", 32'(addr_out), 32'h0);              // R1
      chk(1, "reset burst_active", 32'(burst_active), 32'h0);      // R1
      chk(1, "reset beat_idx", 32'(beat_idx), 32'h0);              // R1

      // idle advances do nothing (R11)
      step(0, '0, 0, '0, 0, 11);
      step(0, '0, 0, '0, 0, 11);

      // linear from 2: 2,3,0,1 then end (R2, R5, R7, R10)
      order_il = 1'b0;
      step(1, 20'h12342, 0, '0, 1, 2);   // R2
      step(0, '0, 0, '0, 0, 7);          // R7
      step(0, '0, 0, '0, 0, 5);          // R5
      step(0, '0, 0, '0, 0, 7);          // R7
      step(0, '0, 0, '0, 0, 10);         // R10
      step(0, '0, 0, '0, 0, 11);         // R11

      // linear from 3: upper bits must not carry (R9)
      step(1, 20'h0ABC7, 0, '0, 0, 2);
      step(0, '0, 0, '0, 0, 9);          // R9
      step(0, '0, 0, '0, 0, 9);          // R9
      step(0, '0, 0, '0, 0, 9);          // R9
      step(0, '0, 0, '0, 0, 10);         // R10

      // interleaved from 1 with holds: 1,0,3,2 (R3, R6, R8)
      order_il = 1'b1;
      step(0, '0, 1, 20'h55551, 0, 3);   // R3
      step(0, '0, 0, '0, 0, 8);          // R8
      step(0, '0, 0, '0, 1, 6);          // R6
      step(0, '0, 0, '0, 1, 6);          // R6
      step(0, '0, 0, '0, 0, 8);          // R8
      step(0, '0, 0, '0, 0, 8);          // R8
      step(0, '0, 0, '0, 0, 10);         // R10

      // interleaved from 3: 3,2,1,0 (R8)
      step(1, 20'hF00F3, 0, '0, 0, 8);
      step(0, '0, 0, '0, 0, 8);          // R8
      step(0, '0, 0, '0, 0, 8);          // R8
      step(0, '0, 0, '0, 0, 8);          // R8

      // both strobes: processor wins (R4)
      step(1, 20'h22222, 1, 20'h33333, 0, 4);
      step(0, '0, 0, '0, 0, 5);          // R5

      // mid-burst reload while advancing (R12)
      order_il = 1'b0;
      step(0, '0, 1, 20'h44446, 0, 12);  // R12
      step(0, '0, 0, '0, 0, 7);          // R7
      step(1, 20'h6789A, 0, '0, 0, 12);  // R12
      step(0, '0, 0, '0, 1, 6);          // R6
      step(0, '0, 0, '0, 0, 7);          // R7

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule